// File: doc/BRIEF.md
# Break Return Address Selector

This block picks the program-counter value that is saved when a debug break trap is taken. The break comparators report a match together with the kind of break. The fetch and branch logic supply the surrounding addresses: the matched instruction, the next sequential instruction, the delayed branch that owns a delay slot, the branch target, and the instruction fetched close to a data access. The selector registers the chosen return address and raises a one-cycle trap strobe.

For a break taken before execution, the block also tells the pipeline, in the same cycle, not to execute the matched instruction.

The return address follows the timing of each break kind:
- A break taken before execution returns to the matched instruction. If that instruction sits in a delay slot, it returns to the branch that owns the slot.
- A break taken after execution returns to the next instruction. On a delayed branch, that next instruction is the branch target.
- An address-only data break returns to the next instruction.
- An address-plus-data break returns to whatever instruction was fetched around the matching access.

Top module: `brk_ret_pc`

## Requirements
- R1: Reset (`rstN` low) clears `savedPc` to zero and `trapTake` to 0.
- R2: With `breakKind` = 2'b00 (fetch, before execution), a match with `inDelaySlot` = 0 loads `savedPc` with `matchPc` on the next clock edge.
- R3: With `breakKind` = 2'b00, a match with `inDelaySlot` = 1 loads `savedPc` with `branchPc`, the address of the owning delayed branch.
- R4: `suppressExec` is combinational. It is 1 exactly when `matchValid` = 1 and `breakKind` = 2'b00, whatever the branch and slot flags are.
- R5: With `breakKind` = 2'b01 (fetch, after execution), a match with `isDelayedBranch` = 0 loads `savedPc` with `nextPc`.
- R6: With `breakKind` = 2'b01, a match with `isDelayedBranch` = 1 loads `savedPc` with `branchTarget`.
- R7: With `breakKind` = 2'b10 (data, address only), a match loads `savedPc` with `nextPc`. Both `inDelaySlot` and `isDelayedBranch` are ignored.
- R8: With `breakKind` = 2'b11 (data, address plus data), a match loads `savedPc` with `fetchPc`. Both flags are ignored.
- R9: `trapTake` is 1 in the cycle after each clock edge that sampled `matchValid` = 1, and 0 otherwise.
- R10: On an edge where `matchValid` = 0, `savedPc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| matchValid | input | 1 | A break condition matched this cycle |
| breakKind | input | 2 | 00 fetch before execution, 01 fetch after execution, 10 data address only, 11 data address plus data |
| matchPc | input | AW | Address of the matched instruction |
| nextPc | input | AW | Address of the next instruction to execute |
| branchPc | input | AW | Address of the delayed branch owning the current delay slot |
| isDelayedBranch | input | 1 | The matched instruction is a delayed branch |
| branchTarget | input | AW | Destination address of that delayed branch |
| inDelaySlot | input | 1 | The matched instruction sits in a delay slot |
| fetchPc | input | AW | Address of the instruction fetched near the matching data access |
| savedPc | output | AW | Registered return address for the trap |
| suppressExec | output | 1 | Do not execute the matched instruction |
| trapTake | output | 1 | One-cycle strobe: the trap is taken |

## Verification
The assertions take for granted that the address inputs are stable and meaningful during a cycle where `matchValid` is high. They also assume that `breakKind` and the two context flags are known values whenever a match is reported; the flags may be set in any combination.

The stimulus sweeps every kind against every flag pairing, with and without a match, so it includes flag combinations the pipeline would never produce. The address inputs are derived from the sweep index so that all five sources are distinct in every vector.

// File: rtl/brk_ret_pkg.sv
package brk_ret_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH_PRE  = 2'b00,
    KIND_FETCH_POST = 2'b01,
    KIND_DATA_ADDR  = 2'b10,
    KIND_DATA_VAL   = 2'b11
  } brkKind_e;

  typedef enum logic [2:0] {
    SRC_MATCH  = 3'd0,
    SRC_BRANCH = 3'd1,
    SRC_NEXT   = 3'd2,
    SRC_TARGET = 3'd3,
    SRC_FETCH  = 3'd4
  } pcSrc_e;

  typedef struct packed {
    logic   load;
    pcSrc_e src;
    logic   suppress;
  } brkStrobe_t;

endpackage

// File: rtl/brk_ret_ctrl.sv
module brk_ret_ctrl
  import brk_ret_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchValid,
  input  logic [1:0] breakKind,
  input  logic       isDelayedBranch,
  input  logic       inDelaySlot,
  output brkStrobe_t strobe,
  output logic       trapTake
);

  brkKind_e kind;
  assign kind = brkKind_e'(breakKind);

  always_comb begin
    strobe.load     = matchValid;
    strobe.suppress = matchValid && (kind == KIND_FETCH_PRE);
    unique case (kind)
      KIND_FETCH_PRE:  strobe.src = inDelaySlot ? SRC_BRANCH : SRC_MATCH;
      KIND_FETCH_POST: strobe.src = isDelayedBranch ? SRC_TARGET : SRC_NEXT;
      KIND_DATA_ADDR:  strobe.src = SRC_NEXT;
      default:         strobe.src = SRC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapTake <= 1'b0;
    else       trapTake <= matchValid;
  end

  // R9: the strobe lasts a single cycle unless matches come back to back
  a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && !$past(matchValid)) |-> 1'b0);

endmodule

// File: rtl/brk_ret_dp.sv
module brk_ret_dp
  import brk_ret_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  brkStrobe_t    strobe,
  input  logic [AW-1:0] matchPc,
  input  logic [AW-1:0] nextPc,
  input  logic [AW-1:0] branchPc,
  input  logic [AW-1:0] branchTarget,
  input  logic [AW-1:0] fetchPc,
  output logic [AW-1:0] savedPc
);

  logic [AW-1:0] pcSel;

  always_comb begin
    unique case (strobe.src)
      SRC_MATCH:  pcSel = matchPc;
      SRC_BRANCH: pcSel = branchPc;
      SRC_NEXT:   pcSel = nextPc;
      SRC_TARGET: pcSel = branchTarget;
      default:    pcSel = fetchPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            savedPc <= '0;
    else if (strobe.load) savedPc <= pcSel;
  end

  // R10: without a load strobe the return address register holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(savedPc));

endmodule

// File: rtl/brk_ret_pc.sv
module brk_ret_pc
  import brk_ret_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          matchValid,
  input  logic [1:0]    breakKind,
  input  logic [AW-1:0] matchPc,
  input  logic [AW-1:0] nextPc,
  input  logic [AW-1:0] branchPc,
  input  logic          isDelayedBranch,
  input  logic [AW-1:0] branchTarget,
  input  logic          inDelaySlot,
  input  logic [AW-1:0] fetchPc,
  output logic [AW-1:0] savedPc,
  output logic          suppressExec,
  output logic          trapTake
);

  brkStrobe_t strobe;

  brk_ret_ctrl uCtrl (
    .clk             (clk),
    .rstN            (rstN),
    .matchValid      (matchValid),
    .breakKind       (breakKind),
    .isDelayedBranch (isDelayedBranch),
    .inDelaySlot     (inDelaySlot),
    .strobe          (strobe),
    .trapTake        (trapTake)
  );

  brk_ret_dp #(.AW(AW)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .matchPc      (matchPc),
    .nextPc       (nextPc),
    .branchPc     (branchPc),
    .branchTarget (branchTarget),
    .fetchPc      (fetchPc),
    .savedPc      (savedPc)
  );

  assign suppressExec = strobe.suppress;

  // R4: suppression never appears without a match
  a_r4_suppress_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    suppressExec |-> matchValid);

  // R9: a match is followed by the trap strobe
  a_r9_trap_after_match: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |=> trapTake);

  // R2: pre-execution break outside a slot returns to the matched instruction
  a_r2_pre_plain: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && breakKind == 2'b00 && !inDelaySlot) |=> savedPc == $past(matchPc));

  // R3: pre-execution break in a slot returns to the branch
  a_r3_pre_slot: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && breakKind == 2'b00 && inDelaySlot) |=> savedPc == $past(branchPc));

  // R6: post-execution break on a delayed branch returns to its target
  a_r6_post_branch: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && breakKind == 2'b01 && isDelayedBranch) |=> savedPc == $past(branchTarget));

  // R8: address-plus-data break returns to the nearby fetched instruction
  a_r8_data_val: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && breakKind == 2'b11) |=> savedPc == $past(fetchPc));

endmodule

// File: tb/brk_ret_pc_test.sv
`timescale 1ns/1ps
module brk_ret_pc_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          matchValid;
  logic [1:0]    breakKind;
  logic [AW-1:0] matchPc, nextPc, branchPc, branchTarget, fetchPc;
  logic          isDelayedBranch, inDelaySlot;
  logic [AW-1:0] savedPc;
  logic          suppressExec, trapTake;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  brk_ret_pc #(.AW(AW)) uut (
    .clk(clk), .rstN(rstN), .matchValid(matchValid), .breakKind(breakKind),
    .matchPc(matchPc), .nextPc(nextPc), .branchPc(branchPc),
    .isDelayedBranch(isDelayedBranch), .branchTarget(branchTarget),
    .inDelaySlot(inDelaySlot), .fetchPc(fetchPc),
    .savedPc(savedPc), .suppressExec(suppressExec), .trapTake(trapTake)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string reqFor(input int k, input bit ds, input bit db);
    case (k)
      0: return ds ? "R3" : "R2";
      1: return db ? "R6" : "R5";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic [AW-1:0] expSaved;

  initial begin
    rstN = 1'b0; matchValid = 1'b0; breakKind = 2'b00;
    matchPc = '0; nextPc = '0; branchPc = '0; branchTarget = '0; fetchPc = '0;
    isDelayedBranch = 1'b0; inDelaySlot = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", savedPc, '0);
    check("R1", {31'b0, trapTake}, 32'd0);
    rstN = 1'b1;
    expSaved = '0;
    for (int rep = 0; rep < 2; rep++) begin
      for (int n = 0; n < 32; n++) begin
        bit mv, ds, db;
        int k;
        mv = (rep == 0) ? n[0] : ~n[4];
        ds = n[1];
        db = n[2];
        k  = n[4:3];
        @(negedge clk);
        matchValid = mv; breakKind = k[1:0];
        inDelaySlot = ds; isDelayedBranch = db;
        matchPc      = 32'h0001_0000 + 32'(n * 16 + rep * 1024);
        nextPc       = matchPc + 32'd2;
        branchPc     = matchPc - 32'd2;
        branchTarget = 32'h0800_0000 ^ 32'(n << 4) ^ 32'(rep << 12);
        fetchPc      = matchPc + 32'd6;
        #1;
        check("R4", {31'b0, suppressExec}, {31'b0, (mv && k == 0)});
        if (mv) begin
          case (k)
            0: expSaved = ds ? branchPc : matchPc;
            1: expSaved = db ? branchTarget : nextPc;
            2: expSaved = nextPc;
            default: expSaved = fetchPc;
          endcase
        end
        @(negedge clk);
        check("R9", {31'b0, trapTake}, {31'b0, mv});
        check(mv ? reqFor(k, ds, db) : "R10", savedPc, expSaved);
      end
    end
    @(negedge clk);
    matchValid = 1'b0;
    @(negedge clk);
    check("R9", {31'b0, trapTake}, 32'd0);
    check("R10", savedPc, expSaved);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule